// File: doc/BRIEF.md
# Strap-Configured Serial Port with Hardware Handshake

This block is a full-duplex asynchronous serial port. Every character carries eight data bits. A parity bit is optional and, when present, is even. One or two stop bits can be selected. The line rate and the frame format are fixed once, when the block leaves reset. On the first clock after reset is released, two strap inputs are captured. Three of their four combinations pick a fixed line rate. The fourth combination (both low) takes the rate from a 4-bit parameter index. Parity and stop-bit count always come from the parameter inputs. A divisor table for the 16x oversampling tick is computed at elaboration from the system clock frequency. The boot logic latches one entry of that table.

The transmitter will not start a character while the clear-to-send input is high (deasserted). It reports through `tx_ready` when a load will be accepted. The receiver oversamples at 16x, checks the start bit at mid-bit, and samples each data bit at its centre. It delivers the byte with a one-cycle strobe, together with the parity and framing error flags. A one-byte holding register drives request-to-send. A falling edge on the idle receive line raises a one-cycle wake pulse for a power-save controller.

Top module: `strap_uart`

## Requirements
- R1: While `rst` is high: `txd` is 1, `rts_n` is 0, and `tx_ready`, `rx_valid`, `rx_par_err`, `rx_frm_err` and `wake` are 0.
- R2: The straps are captured on the first clock edge at which `rst` is low. Rate selection by `{strap_a,strap_b}`: 11 selects 921600 baud, 10 selects 115200, 01 selects 9600, 00 uses the parameter index. The tick divisor is round(CLK_HZ/(16*baud)), and one bit lasts 16 times that divisor in clocks.
- R3: The parameter index values 0 to 10 select 2400, 4800, 7200, 9600, 19200, 38400, 57600, 115200, 230400, 460800 and 921600 baud, in that order. The index values 11 to 15 select 9600.
- R4: After capture, changes on `strap_a`, `strap_b`, `prm_rate`, `prm_parity` and `prm_two_stop` have no effect on line rate or frame format until the next reset.
- R5: A transmitted frame is: start bit 0, then `tx_data` LSB first, then the even parity bit (XOR of the data) if parity was selected, then one stop bit of 1 (two if `prm_two_stop` was set). The line idles at 1. `tx_ready` stays low until the last stop bit ends.
- R6: `tx_ready` is high only when the boot capture is done, the transmitter is idle and `cts_n` is 0. A `tx_load` while `tx_ready` is low is dropped. Raising `cts_n` in the middle of a frame does not cut that frame short.
- R7: The receiver needs a start bit that is still low at mid-bit. It then samples eight data bits, LSB first, at their centres and pulses `rx_valid` for one cycle, with `rx_data` holding the byte.
- R8: `rx_frm_err` pulses together with `rx_valid` when the first stop bit is sampled low. When parity was selected, `rx_par_err` pulses together with `rx_valid` if the received parity bit differs from the XOR of the data.
- R9: `rts_n` goes to 1 on the cycle after `rx_valid` and returns to 0 on the cycle after `rx_read`.
- R10: `wake` pulses for one cycle on a falling edge of `rxd` while the receiver is idle. It does not pulse for edges inside a frame.
- R11: A low pulse on `rxd` shorter than half a bit produces no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_a | input | 1 | Rate strap, high bit of the selection |
| strap_b | input | 1 | Rate strap, low bit of the selection |
| prm_rate | input | 4 | Stored rate index used when both straps are low |
| prm_parity | input | 1 | Stored setting: even parity bit present |
| prm_two_stop | input | 1 | Stored setting: two stop bits on transmit |
| tx_data | input | 8 | Byte to send |
| tx_load | input | 1 | Start sending `tx_data` (taken only while `tx_ready`) |
| tx_ready | output | 1 | Transmitter will accept a load |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear to send, active low |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: byte received |
| rx_par_err | output | 1 | Parity mismatch, with `rx_valid` |
| rx_frm_err | output | 1 | Stop bit low, with `rx_valid` |
| rx_read | input | 1 | Host has taken the held byte |
| rts_n | output | 1 | Request to send, active low; high while a byte is held |
| wake | output | 1 | One-cycle pulse on idle-line start activity |

## Verification
The bench boots the block under every strap combination and under ten parameter indices plus one out-of-range index. For each boot it measures two whole bit periods on the transmit line, which separates every pair of divisors in the table. Transmitted frames use the bytes 0x00, 0xFF, 0xA3, 0x96 and 0x01, with and without parity and with one and two stop bits. These patterns separate bit order, parity polarity and stop-bit count. Received frames include good ones, frames with flipped parity, frames with a low stop bit, and a short glitch. These tell a real error apart from a false one and a real start apart from noise. Changing the straps and parameters after boot, and raising `cts_n` before and during a frame, show that those inputs are ignored where the requirements say so.

// File: rtl/strap_uart_pkg.sv
package strap_uart_pkg;

    localparam int DIV_W    = 16;
    localparam int IDX_W    = 4;
    localparam int N_IDX    = 2 ** IDX_W;
    localparam int DATA_W   = 8;
    localparam int BIT_W    = $clog2(DATA_W);
    localparam int OVS      = 16;
    localparam int OVS_W    = $clog2(OVS);

    localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);
    localparam logic [OVS_W-1:0] OVS_MID  = OVS_W'(OVS / 2 - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    localparam logic [IDX_W-1:0] IDX_MAX    = IDX_W'(10);
    localparam logic [IDX_W-1:0] IDX_921K   = IDX_W'(10);
    localparam logic [IDX_W-1:0] IDX_115K   = IDX_W'(7);
    localparam logic [IDX_W-1:0] IDX_9K6    = IDX_W'(3);

    typedef struct packed {
        logic parity_en;
        logic two_stop;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_t;

    function automatic int unsigned baud_of(input int unsigned idx);
        case (idx)
            0:       return 2400;
            1:       return 4800;
            2:       return 7200;
            3:       return 9600;
            4:       return 19200;
            5:       return 38400;
            6:       return 57600;
            7:       return 115200;
            8:       return 230400;
            9:       return 460800;
            10:      return 921600;
            default: return 9600;
        endcase
    endfunction

    function automatic int unsigned div_of(input int unsigned clk_hz, input int unsigned idx);
        int unsigned r;
        int unsigned d;
        r = baud_of(idx);
        d = (clk_hz + 8 * r) / (16 * r);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic logic [IDX_W-1:0] pick_idx(input logic sa, input logic sb,
                                                  input logic [IDX_W-1:0] prm);
        case ({sa, sb})
            2'b11:   return IDX_921K;
            2'b10:   return IDX_115K;
            2'b01:   return IDX_9K6;
            default: return (prm > IDX_MAX) ? IDX_9K6 : prm;
        endcase
    endfunction

endpackage

// File: rtl/uart_boot_cfg.sv
module uart_boot_cfg
    import strap_uart_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_a,
    input  logic             strap_b,
    input  logic [IDX_W-1:0] prm_rate,
    input  logic             prm_parity,
    input  logic             prm_two_stop,
    output logic             booted,
    output frame_cfg_t       cfg,
    output logic [DIV_W-1:0] div
);

    logic [DIV_W-1:0] div_tab [N_IDX];
    logic [IDX_W-1:0] sel_idx;

    for (genvar i = 0; i < N_IDX; i++) begin : g_div
        assign div_tab[i] = DIV_W'(div_of(CLK_HZ, i));
    end

    assign sel_idx = pick_idx(strap_a, strap_b, prm_rate);

    always_ff @(posedge clk) begin
        if (rst) begin
            booted <= 1'b0;
            cfg    <= '0;
            div    <= '0;
        end else if (!booted) begin
            booted        <= 1'b1;
            cfg.parity_en <= prm_parity;
            cfg.two_stop  <= prm_two_stop;
            div           <= div_tab[sel_idx];
        end
    end

endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen
    import strap_uart_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = (cnt == div - DIV_W'(1));
    assign tick = en && wrap;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import strap_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              booted,
    input  logic              tick,
    input  logic              parity_en,
    input  logic              two_stop,
    input  logic              cts_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              ready,
    output logic              idle
);

    tx_state_t         state;
    logic [DATA_W-1:0] shreg;
    logic [BIT_W-1:0]  bitn;
    logic [OVS_W-1:0]  ocnt;
    logic              par_q;
    logic              stop_n;

    assign idle  = (state == TX_IDLE);
    assign ready = booted && idle && !cts_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            shreg  <= '0;
            bitn   <= '0;
            ocnt   <= '0;
            par_q  <= 1'b0;
            stop_n <= 1'b0;
            txd    <= 1'b1;
        end else if (state == TX_IDLE) begin
            if (load && ready) begin
                shreg <= data;
                par_q <= ^data;
                ocnt  <= '0;
                txd   <= 1'b0;
                state <= TX_START;
            end
        end else if (tick) begin
            if (ocnt != OVS_LAST) begin
                ocnt <= ocnt + 1'b1;
            end else begin
                ocnt <= '0;
                case (state)
                    TX_START: begin
                        txd   <= shreg[0];
                        bitn  <= '0;
                        state <= TX_DATA;
                    end
                    TX_DATA: begin
                        if (bitn == BIT_LAST) begin
                            if (parity_en) begin
                                txd   <= par_q;
                                state <= TX_PAR;
                            end else begin
                                txd    <= 1'b1;
                                stop_n <= 1'b0;
                                state  <= TX_STOP;
                            end
                        end else begin
                            shreg <= shreg >> 1;
                            txd   <= shreg[1];
                            bitn  <= bitn + 1'b1;
                        end
                    end
                    TX_PAR: begin
                        txd    <= 1'b1;
                        stop_n <= 1'b0;
                        state  <= TX_STOP;
                    end
                    TX_STOP: begin
                        if (two_stop && !stop_n) begin
                            stop_n <= 1'b1;
                        end else begin
                            state <= TX_IDLE;
                        end
                    end
                    default: state <= TX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import strap_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              booted,
    input  logic              tick,
    input  logic              parity_en,
    input  logic              rxd_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              par_err,
    output logic              frm_err,
    output logic              wake,
    output logic              idle
);

    logic [2:0]        sync_q;
    logic              rxd_s;
    logic              fall;
    rx_state_t         state;
    logic [DATA_W-1:0] shreg;
    logic [BIT_W-1:0]  bitn;
    logic [OVS_W-1:0]  ocnt;
    logic              par_bit;

    assign rxd_s = sync_q[1];
    assign fall  = sync_q[2] && !sync_q[1];
    assign idle  = (state == RX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[1:0], rxd_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            shreg    <= '0;
            bitn     <= '0;
            ocnt     <= '0;
            par_bit  <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
            wake     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
            wake     <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (booted && fall) begin
                        ocnt  <= '0;
                        wake  <= 1'b1;
                        state <= RX_START;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (ocnt == OVS_MID) begin
                            ocnt <= '0;
                            bitn <= '0;
                            state <= rxd_s ? RX_IDLE : RX_DATA;
                        end else begin
                            ocnt <= ocnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (ocnt == OVS_LAST) begin
                            ocnt  <= '0;
                            shreg <= {rxd_s, shreg[DATA_W-1:1]};
                            bitn  <= bitn + 1'b1;
                            if (bitn == BIT_LAST) begin
                                state <= parity_en ? RX_PAR : RX_STOP;
                            end
                        end else begin
                            ocnt <= ocnt + 1'b1;
                        end
                    end
                end
                RX_PAR: begin
                    if (tick) begin
                        if (ocnt == OVS_LAST) begin
                            ocnt    <= '0;
                            par_bit <= rxd_s;
                            state   <= RX_STOP;
                        end else begin
                            ocnt <= ocnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (ocnt == OVS_LAST) begin
                            ocnt     <= '0;
                            rx_valid <= 1'b1;
                            rx_data  <= shreg;
                            frm_err  <= !rxd_s;
                            par_err  <= parity_en && (par_bit != (^shreg));
                            state    <= RX_IDLE;
                        end else begin
                            ocnt <= ocnt + 1'b1;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/strap_uart.sv
module strap_uart
    import strap_uart_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_a,
    input  logic             strap_b,
    input  logic [IDX_W-1:0] prm_rate,
    input  logic             prm_parity,
    input  logic             prm_two_stop,
    input  logic [7:0]       tx_data,
    input  logic             tx_load,
    output logic             tx_ready,
    output logic             txd,
    input  logic             cts_n,
    input  logic             rxd,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    input  logic             rx_read,
    output logic             rts_n,
    output logic             wake
);

    logic             booted;
    frame_cfg_t       cfg_q;
    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic             tx_idle;
    logic             rx_idle;
    logic             rx_full;

    uart_boot_cfg #(.CLK_HZ(CLK_HZ)) u_boot (
        .clk          (clk),
        .rst          (rst),
        .strap_a      (strap_a),
        .strap_b      (strap_b),
        .prm_rate     (prm_rate),
        .prm_parity   (prm_parity),
        .prm_two_stop (prm_two_stop),
        .booted       (booted),
        .cfg          (cfg_q),
        .div          (div_q)
    );

    uart_tick_gen u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (booted),
        .div  (div_q),
        .tick (tick)
    );

    uart_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .booted    (booted),
        .tick      (tick),
        .parity_en (cfg_q.parity_en),
        .two_stop  (cfg_q.two_stop),
        .cts_n     (cts_n),
        .load      (tx_load),
        .data      (tx_data),
        .txd       (txd),
        .ready     (tx_ready),
        .idle      (tx_idle)
    );

    uart_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .booted    (booted),
        .tick      (tick),
        .parity_en (cfg_q.parity_en),
        .rxd_in    (rxd),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .par_err   (rx_par_err),
        .frm_err   (rx_frm_err),
        .wake      (wake),
        .idle      (rx_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_full <= 1'b0;
        end else if (rx_valid) begin
            rx_full <= 1'b1;
        end else if (rx_read) begin
            rx_full <= 1'b0;
        end
    end

    assign rts_n = rx_full;

endmodule

// File: rtl/strap_uart_chk.sv
module strap_uart_chk
    import strap_uart_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             booted,
    input logic             cts_n,
    input logic             tx_load,
    input logic             tx_ready,
    input logic             tx_idle,
    input logic             txd,
    input logic             rx_idle,
    input logic             rx_valid,
    input logic             rx_par_err,
    input logic             rx_frm_err,
    input logic             rx_read,
    input logic             rts_n,
    input logic             wake,
    input logic [DIV_W-1:0] div_q,
    input logic             parity_en
);

    // R4: the captured divisor never moves once boot capture is done
    p_div_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        (booted && $past(booted)) |-> $stable(div_q));

    // R5: idle transmitter holds the line high
    p_idle_line_high_r5: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> txd);

    // R6: readiness needs clear-to-send
    p_ready_needs_cts_r6: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !cts_n);

    // R6: an idle, not-ready transmitter stays idle whatever tx_load does
    p_no_start_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_idle && !tx_ready) |=> tx_idle);

    // R7: the valid strobe lasts one cycle
    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8: error flags only accompany a delivered byte
    p_err_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_par_err || rx_frm_err) |-> rx_valid);

    // R8: parity errors only when parity was selected
    p_par_err_enabled_r8: assert property (@(posedge clk) disable iff (rst)
        rx_par_err |-> parity_en);

    // R9: request-to-send drops (goes high) after a delivered byte
    p_rts_set_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> rts_n);

    // R9: a read frees the holding register on the next cycle
    p_rts_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_read && !rx_valid) |=> !rts_n);

    // R10: wake is a single-cycle pulse, raised from an idle receiver
    p_wake_single_r10: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    p_wake_from_idle_r10: assert property (@(posedge clk) disable iff (rst)
        wake |-> !$past(rx_idle) == 1'b0);

endmodule

bind strap_uart strap_uart_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .booted     (booted),
    .cts_n      (cts_n),
    .tx_load    (tx_load),
    .tx_ready   (tx_ready),
    .tx_idle    (tx_idle),
    .txd        (txd),
    .rx_idle    (rx_idle),
    .rx_valid   (rx_valid),
    .rx_par_err (rx_par_err),
    .rx_frm_err (rx_frm_err),
    .rx_read    (rx_read),
    .rts_n      (rts_n),
    .wake       (wake),
    .div_q      (div_q),
    .parity_en  (cfg_q.parity_en)
);

// File: tb/sim_strap_uart.sv
module sim_strap_uart;

    localparam int unsigned CLK_HZ = 29_491_200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_a = 1'b1;
    logic       strap_b = 1'b1;
    logic [3:0] prm_rate = 4'd0;
    logic       prm_parity = 1'b0;
    logic       prm_two_stop = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0;
    logic       tx_ready;
    logic       txd;
    logic       cts_n = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_par_err;
    logic       rx_frm_err;
    logic       rx_read = 1'b0;
    logic       rts_n;
    logic       wake;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int         n_valid = 0;
    int         n_wake = 0;
    logic [7:0] cap_data = 8'h00;
    logic       cap_par = 1'b0;
    logic       cap_frm = 1'b0;

    always #10 clk = ~clk;

    strap_uart #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst(rst), .strap_a(strap_a), .strap_b(strap_b),
        .prm_rate(prm_rate), .prm_parity(prm_parity), .prm_two_stop(prm_two_stop),
        .tx_data(tx_data), .tx_load(tx_load), .tx_ready(tx_ready), .txd(txd),
        .cts_n(cts_n), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_read(rx_read),
        .rts_n(rts_n), .wake(wake)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                n_valid  = n_valid + 1;
                cap_data = rx_data;
                cap_par  = rx_par_err;
                cap_frm  = rx_frm_err;
            end
            if (wake) n_wake = n_wake + 1;
        end
    end

    function automatic int baud_for(input int idx);
        case (idx)
            0: return 2400;    1: return 4800;    2: return 7200;
            3: return 9600;    4: return 19200;   5: return 38400;
            6: return 57600;   7: return 115200;  8: return 230400;
            9: return 460800;  10: return 921600;
            default: return 9600;
        endcase
    endfunction

    function automatic int bitlen_for(input int baud);
        return 16 * ((int'(CLK_HZ) + 8 * baud) / (16 * baud));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic boot(input bit sa, input bit sb, input int idx,
                        input bit par, input bit two);
        @(negedge clk);
        rst = 1'b1;
        strap_a = sa; strap_b = sb;
        prm_rate = 4'(idx); prm_parity = par; prm_two_stop = two;
        tx_load = 1'b0; rx_read = 1'b0; rxd = 1'b1; cts_n = 1'b0;
        cycles(3);
        rst = 1'b0;
        cycles(2);
    endtask

    task automatic wait_ready(input string req);
        int n;
        n = 0;
        while (!tx_ready && n < 60000) begin
            @(negedge clk);
            n++;
        end
        if (!tx_ready) chk(1'b0, req, "tx_ready timeout", 0, 1);
    endtask

    // two bit periods between the falls that open d1 and d3 of 0x55
    task automatic measure(output int period);
        int  cyc;
        int  nf;
        int  c2;
        logic prev;
        wait_ready("R2");
        tx_data = 8'h55;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        prev = txd; nf = 1; cyc = 0; c2 = 0; period = -1;
        while (cyc < 70000) begin
            @(negedge clk);
            cyc++;
            if (prev && !txd) begin
                nf++;
                if (nf == 2) c2 = cyc;
                if (nf == 3) begin
                    period = cyc - c2;
                    break;
                end
            end
            prev = txd;
        end
    endtask

    task automatic check_frame(input logic [7:0] d, input int bitlen, input bit par,
                               input bit two, input bit drop_cts, input string req);
        logic exp_bits [0:11];
        int   nbits;
        int   mism;
        nbits = 10 + int'(par) + int'(two);
        exp_bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) exp_bits[1 + i] = d[i];
        if (par) exp_bits[9] = ^d;
        for (int i = 9 + int'(par); i < 12; i++) exp_bits[i] = 1'b1;
        wait_ready(req);
        tx_data = d;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        cycles(bitlen / 2 - 1);
        mism = 0;
        for (int k = 0; k < nbits; k++) begin
            if (txd !== exp_bits[k]) mism++;
            if (k == 1 && drop_cts) cts_n = 1'b1;
            if (k < nbits - 1) cycles(bitlen);
        end
        chk(mism == 0, req, $sformatf("frame bits of %02h mismatching", d), mism, 0);
        chk(tx_ready == 1'b0, req, "tx_ready during last stop bit", int'(tx_ready), 0);
        cycles(bitlen);
        chk(tx_ready == !cts_n, req, "tx_ready after frame", int'(tx_ready), int'(!cts_n));
        cts_n = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] d, input int bitlen, input bit par,
                           input bit flip, input bit stopv, input string req);
        int v0;
        int w0;
        v0 = n_valid; w0 = n_wake;
        rxd = 1'b0; cycles(bitlen);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; cycles(bitlen);
        end
        if (par) begin
            rxd = (^d) ^ flip; cycles(bitlen);
        end
        rxd = stopv; cycles(bitlen);
        rxd = 1'b1; cycles(2 * bitlen);
        chk(n_valid == v0 + 1, "R7", "valid strobes per frame", n_valid - v0, 1);
        chk(cap_data == d, "R7", "received byte", int'(cap_data), int'(d));
        chk(cap_par == (par && flip), req, "parity error flag", int'(cap_par), int'(par && flip));
        chk(cap_frm == !stopv, req, "framing error flag", int'(cap_frm), int'(!stopv));
        chk(n_wake == w0 + 1, "R10", "wake pulses per frame", n_wake - w0, 1);
        chk(rts_n == 1'b1, "R9", "rts_n while byte held", int'(rts_n), 1);
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
        @(negedge clk);
        chk(rts_n == 1'b0, "R9", "rts_n after read", int'(rts_n), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int per;
        int bl;
        int v0;
        int w0;
        int lows;

        // R1 reset state
        cycles(4);
        chk(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
        chk(rts_n == 1'b0, "R1", "rts_n in reset", int'(rts_n), 0);
        chk(tx_ready == 1'b0, "R1", "tx_ready in reset", int'(tx_ready), 0);
        chk(!rx_valid && !rx_par_err && !rx_frm_err && !wake, "R1",
            "receive flags in reset", int'(rx_valid | rx_par_err | rx_frm_err | wake), 0);

        // straps 11: fastest rate, no parity, one stop
        boot(1'b1, 1'b1, 0, 1'b0, 1'b0);
        bl = bitlen_for(921600);
        measure(per);
        chk(per == 2 * bl, "R2", "two bit periods, straps 11", per, 2 * bl);

        // R4: change every setting after capture
        strap_a = 1'b0; strap_b = 1'b0; prm_rate = 4'd3;
        prm_parity = 1'b1; prm_two_stop = 1'b1;
        measure(per);
        chk(per == 2 * bl, "R4", "rate after late strap change", per, 2 * bl);
        check_frame(8'hA3, bl, 1'b0, 1'b0, 1'b0, "R4");
        check_frame(8'h00, bl, 1'b0, 1'b0, 1'b0, "R5");
        check_frame(8'hFF, bl, 1'b0, 1'b0, 1'b0, "R5");

        // R6: blocked while cts_n high
        cts_n = 1'b1;
        cycles(2);
        chk(tx_ready == 1'b0, "R6", "tx_ready with cts_n high", int'(tx_ready), 0);
        tx_data = 8'h00;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        lows = 0;
        for (int i = 0; i < 4 * bl; i++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        chk(lows == 0, "R6", "line activity after blocked load", lows, 0);
        cts_n = 1'b0;
        cycles(2);
        chk(tx_ready == 1'b1, "R6", "tx_ready after cts_n low", int'(tx_ready), 1);

        // receive at the fastest rate, no parity
        send_rx(8'h3C, bl, 1'b0, 1'b0, 1'b1, "R7");
        send_rx(8'h55, bl, 1'b0, 1'b0, 1'b1, "R7");
        send_rx(8'hFF, bl, 1'b0, 1'b0, 1'b1, "R7");
        send_rx(8'h81, bl, 1'b0, 1'b0, 1'b0, "R8");

        // R11: short glitch rejected
        v0 = n_valid; w0 = n_wake;
        rxd = 1'b0; cycles(4);
        rxd = 1'b1; cycles(3 * bl);
        chk(n_valid == v0, "R11", "strobes after glitch", n_valid - v0, 0);
        chk(n_wake == w0 + 1, "R10", "wake on idle-line glitch", n_wake - w0, 1);

        // straps 10: 115.2k with parity and two stops from parameters
        boot(1'b1, 1'b0, 0, 1'b1, 1'b1);
        bl = bitlen_for(115200);
        measure(per);
        chk(per == 2 * bl, "R2", "two bit periods, straps 10", per, 2 * bl);
        check_frame(8'h96, bl, 1'b1, 1'b1, 1'b0, "R5");
        check_frame(8'h01, bl, 1'b1, 1'b1, 1'b0, "R5");
        check_frame(8'hA3, bl, 1'b1, 1'b1, 1'b1, "R6");
        send_rx(8'hC5, bl, 1'b1, 1'b0, 1'b1, "R8");
        send_rx(8'hC5, bl, 1'b1, 1'b1, 1'b1, "R8");
        send_rx(8'h7E, bl, 1'b1, 1'b1, 1'b1, "R8");
        send_rx(8'h00, bl, 1'b1, 1'b0, 1'b1, "R8");

        // straps 01: 9.6k regardless of the parameter index
        boot(1'b0, 1'b1, 10, 1'b0, 1'b0);
        bl = bitlen_for(9600);
        measure(per);
        chk(per == 2 * bl, "R2", "two bit periods, straps 01", per, 2 * bl);

        // straps 00: parameter index sweep, then an out-of-range index
        for (int idx = 1; idx <= 10; idx++) begin
            boot(1'b0, 1'b0, idx, 1'b0, 1'b0);
            bl = bitlen_for(baud_for(idx));
            measure(per);
            chk(per == 2 * bl, "R3", $sformatf("two bit periods, index %0d", idx), per, 2 * bl);
        end
        boot(1'b0, 1'b0, 13, 1'b0, 1'b0);
        bl = bitlen_for(9600);
        measure(per);
        chk(per == 2 * bl, "R3", "two bit periods, index 13", per, 2 * bl);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule